// File: doc/BRIEF.md
# Host bus cycle decoder

This block sits on the system-board side of a 64-bit processor bus. When the processor asserts its address strobe, the block captures the cycle-type code, the quadword address and the active-low byte enables. It keeps them for the whole bus cycle and turns them into one-hot strobes for the board. The strobes are interrupt acknowledge, special cycle, I/O read, I/O write, code fetch, memory read and memory write. A reserved type code is reported as invalid. The block drops everything once the cycle-ending ready is sampled.

During a special cycle, the single active byte enable names a board event: shutdown, cache flush, halt, write-back, flush acknowledge or branch trace. A shutdown event starts a soft-reset pulse back to the processor. The pulse lasts a configurable number of clocks. The block also decodes one I/O write port, at byte address 43h, as a chip-select example.

Top module: `host_cycle_decoder`

## Requirements
- R1: While rst_ni is low and after its release, every strobe, every event, be_err_o, port_sel_o and init_o are low.
- R2: A clock edge with addr_strobe_ni low captures cyc_type_i = {memory, data, write}. From the next cycle exactly one strobe is high: 000 inta_o, 001 special_o, 010 io_rd_o, 011 io_wr_o, 100 fetch_o, 110 mem_rd_o, 111 mem_wr_o.
- R3: Type 101 raises invalid_o and no other strobe.
- R4: Strobes, events and port_sel_o hold their values, whatever the inputs do, until an edge with ready_ni low. After that edge they are all low.
- R5: In a special cycle with exactly one active (low) byte enable among bits 0..5, evt_o carries that bit position. Bit 0 is shutdown, 1 flush, 2 halt, 3 write-back, 4 flush acknowledge and 5 branch trace.
- R6: A special cycle with no active byte enable, with more than one, or with only bit 6 or bit 7 active raises be_err_o and leaves evt_o at zero.
- R7: A shutdown special cycle sets init_o high starting two cycles after the strobe edge, for exactly INIT_LEN consecutive cycles.
- R8: A shutdown that is decoded while init_o is high is absorbed and does not lengthen the pulse. A later shutdown, once the pulse has ended, starts a new one.
- R9: port_sel_o is high only in an I/O write whose quadword address equals PORT_ADDR>>3 (8 by default) and whose byte enable PORT_ADDR mod 8 (bit 3) is low.
- R10: ready_ni has no effect while no cycle is held. An address strobe sampled in the same edge as ready_ni starts the new cycle with the new type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_strobe_ni | input | 1 | Address strobe, active low |
| cyc_type_i | input | 3 | Cycle type {memory, data, write} |
| qw_addr_i | input | ADDR_W | Quadword address (byte address bits 31:3) |
| be_ni | input | 8 | Byte enables, active low |
| ready_ni | input | 1 | Cycle-ending ready, active low |
| inta_o | output | 1 | Interrupt acknowledge cycle |
| special_o | output | 1 | Special cycle |
| io_rd_o | output | 1 | I/O read |
| io_wr_o | output | 1 | I/O write |
| fetch_o | output | 1 | Code fetch |
| mem_rd_o | output | 1 | Memory data read |
| mem_wr_o | output | 1 | Memory write |
| invalid_o | output | 1 | Reserved type seen |
| evt_o | output | 6 | Special-cycle event, one-hot |
| be_err_o | output | 1 | Malformed special-cycle byte enables |
| port_sel_o | output | 1 | Example I/O write port select |
| init_o | output | 1 | Soft-reset request pulse |

## Verification
The assertions take for granted that the address strobe is low for a single clock per cycle and that ready is returned only while a cycle is held. The stall and release properties are written in those terms. The bench releases the strobe at the negative edge after it drives it. It returns ready only inside a cycle, after zero to two wait cycles. The only departures are two directed cases: ready while idle, and ready on the same edge as a new strobe. For both of these the expected result is stated in R10.

// File: rtl/hcd_pkg.sv
package hcd_pkg;
  localparam int N_KIND = 8;
  localparam int N_EVT  = 6;
  // kind index equals the captured 3-bit type code
  localparam int K_INTA    = 0;
  localparam int K_SPECIAL = 1;
  localparam int K_IORD    = 2;
  localparam int K_IOWR    = 3;
  localparam int K_FETCH   = 4;
  localparam int K_RSVD    = 5;
  localparam int K_MEMRD   = 6;
  localparam int K_MEMWR   = 7;
  localparam int EV_SHUTDOWN = 0;
endpackage

// File: rtl/hcd_cycle_latch.sv
module hcd_cycle_latch #(
  parameter int ADDR_W = 29,
  parameter int BE_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_ni,
  input  logic              ready_ni,
  input  logic [2:0]        type_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_ni,
  output logic              active_o,
  output logic              start_o,
  output logic [2:0]        type_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BE_W-1:0]   be_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      start_o  <= 1'b0;
      type_o   <= '0;
      addr_o   <= '0;
      be_no    <= '1;
    end else begin
      start_o <= 1'b0;
      if (!strobe_ni) begin  // new strobe wins over ready
        active_o <= 1'b1;
        start_o  <= 1'b1;
        type_o   <= type_i;
        addr_o   <= addr_i;
        be_no    <= be_ni;
      end else if (active_o && !ready_ni) begin
        active_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hcd_special_decode.sv
module hcd_special_decode #(
  parameter int BE_W  = 8,
  parameter int N_EVT = 6
) (
  input  logic             en_i,
  input  logic [BE_W-1:0]  be_ni,
  output logic [N_EVT-1:0] evt_o,
  output logic             err_o
);
  logic [BE_W-1:0] act;
  logic            single;
  logic            in_range;

  assign act      = ~be_ni;
  assign single   = $onehot(act);
  assign in_range = |act[N_EVT-1:0];

  for (genvar k = 0; k < N_EVT; k++) begin : g_evt
    assign evt_o[k] = en_i && single && act[k];
  end

  assign err_o = en_i && !(single && in_range);
endmodule

// File: rtl/hcd_init_pulse.sv
module hcd_init_pulse #(
  parameter int LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;  // retrigger absorbed
    else if (trig_i)          cnt_q <= CW'(LEN);
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/host_cycle_decoder.sv
module host_cycle_decoder
  import hcd_pkg::*;
#(
  parameter int          ADDR_W    = 29,
  parameter int          INIT_LEN  = 8,
  parameter logic [31:0] PORT_ADDR = 32'h43
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_strobe_ni,
  input  logic [2:0]        cyc_type_i,
  input  logic [ADDR_W-1:0] qw_addr_i,
  input  logic [7:0]        be_ni,
  input  logic              ready_ni,
  output logic              inta_o,
  output logic              special_o,
  output logic              io_rd_o,
  output logic              io_wr_o,
  output logic              fetch_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              invalid_o,
  output logic [5:0]        evt_o,
  output logic              be_err_o,
  output logic              port_sel_o,
  output logic              init_o
);
  localparam int BE_W = 8;
  localparam logic [ADDR_W-1:0] PORT_QW = ADDR_W'(PORT_ADDR >> 3);
  localparam int PORT_LANE = int'(PORT_ADDR[2:0]);

  logic              active, start;
  logic [2:0]        type_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BE_W-1:0]   be_nq;
  logic [N_KIND-1:0] kind_oh;

  hcd_cycle_latch #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_latch (
    .clk_i, .rst_ni,
    .strobe_ni(addr_strobe_ni), .ready_ni,
    .type_i(cyc_type_i), .addr_i(qw_addr_i), .be_ni,
    .active_o(active), .start_o(start),
    .type_o(type_q), .addr_o(addr_q), .be_no(be_nq)
  );

  for (genvar k = 0; k < N_KIND; k++) begin : g_kind
    assign kind_oh[k] = active && (type_q == 3'(k));
  end

  assign inta_o    = kind_oh[K_INTA];
  assign special_o = kind_oh[K_SPECIAL];
  assign io_rd_o   = kind_oh[K_IORD];
  assign io_wr_o   = kind_oh[K_IOWR];
  assign fetch_o   = kind_oh[K_FETCH];
  assign invalid_o = kind_oh[K_RSVD];
  assign mem_rd_o  = kind_oh[K_MEMRD];
  assign mem_wr_o  = kind_oh[K_MEMWR];

  hcd_special_decode #(.BE_W(BE_W), .N_EVT(N_EVT)) u_spec (
    .en_i(kind_oh[K_SPECIAL]), .be_ni(be_nq),
    .evt_o, .err_o(be_err_o)
  );

  assign port_sel_o = kind_oh[K_IOWR] && (addr_q == PORT_QW) && !be_nq[PORT_LANE];

  hcd_init_pulse #(.LEN(INIT_LEN)) u_init (
    .clk_i, .rst_ni,
    .trig_i(start && evt_o[EV_SHUTDOWN]),
    .pulse_o(init_o)
  );
endmodule

// File: rtl/host_cycle_decoder_chk.sv
module host_cycle_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       addr_strobe_ni,
  input logic       ready_ni,
  input logic [7:0] kinds_i,
  input logic [5:0] evt_i,
  input logic       be_err_i,
  input logic       port_sel_i,
  input logic       io_wr_i,
  input logic       special_i,
  input logic       init_i
);
  assert_one_kind_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(kinds_i));
  assert_strobe_loads_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_strobe_ni |=> (kinds_i != 8'h00));
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((kinds_i != 8'h00) && addr_strobe_ni && ready_ni) |=>
      ($stable(kinds_i) && $stable(evt_i) && $stable(port_sel_i)));
  assert_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((kinds_i != 8'h00) && addr_strobe_ni && !ready_ni) |=>
      (kinds_i == 8'h00 && evt_i == 6'h00 && !port_sel_i));
  assert_evt_special_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != 6'h00) |-> (special_i && $onehot(evt_i) && !be_err_i));
  assert_err_special_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_err_i |-> (special_i && evt_i == 6'h00));
  assert_init_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_i) |-> $past(evt_i[0]));
  assert_port_iowr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_sel_i |-> io_wr_i);
endmodule

bind host_cycle_decoder host_cycle_decoder_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .addr_strobe_ni(addr_strobe_ni), .ready_ni(ready_ni),
  .kinds_i({mem_wr_o, mem_rd_o, invalid_o, fetch_o, io_wr_o, io_rd_o, special_o, inta_o}),
  .evt_i(evt_o), .be_err_i(be_err_o), .port_sel_i(port_sel_o),
  .io_wr_i(io_wr_o), .special_i(special_o), .init_i(init_o)
);

// File: tb/host_cycle_decoder_tb_top.sv
`timescale 1ns/1ps
module host_cycle_decoder_tb_top;
  localparam int AW = 29;
  localparam int L  = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic addr_strobe_ni = 1'b1, ready_ni = 1'b1;
  logic [2:0] cyc_type_i = '0;
  logic [AW-1:0] qw_addr_i = '0;
  logic [7:0] be_ni = '1;
  logic inta_o, special_o, io_rd_o, io_wr_o, fetch_o, mem_rd_o, mem_wr_o, invalid_o;
  logic [5:0] evt_o;
  logic be_err_o, port_sel_o, init_o;

  int n_chk = 0, n_bad = 0, init_hi = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  host_cycle_decoder #(.ADDR_W(AW), .INIT_LEN(L), .PORT_ADDR(32'h43)) dut_i (.*);

  always @(negedge clk_i) if (init_o) init_hi++;

  function automatic logic [7:0] kinds();
    return {mem_wr_o, mem_rd_o, invalid_o, fetch_o, io_wr_o, io_rd_o, special_o, inta_o};
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_evt(logic [2:0] t, logic [7:0] ben);
    logic [7:0] a = ~ben;
    if (t == 3'd1 && $countones(a) == 1 && a[7:6] == 2'b00) return a[5:0];
    return 6'h0;
  endfunction

  function automatic logic exp_err(logic [2:0] t, logic [7:0] ben);
    return (t == 3'd1) && (exp_evt(t, ben) == 6'h0);
  endfunction

  function automatic logic exp_port(logic [2:0] t, logic [AW-1:0] a, logic [7:0] ben);
    return (t == 3'd3) && (a == AW'(8)) && !ben[3];
  endfunction

  task automatic check_held(logic [2:0] t, logic [AW-1:0] a, logic [7:0] ben, string ph);
    chk({(t == 3'd5) ? "R3 " : "R2 ", ph}, kinds(), 8'h01 << t);
    chk({"R5 ", ph}, evt_o, exp_evt(t, ben));
    chk({"R6 ", ph}, be_err_o, exp_err(t, ben));
    chk({"R9 ", ph}, port_sel_o, exp_port(t, a, ben));
  endtask

  task automatic scramble();
    cyc_type_i = 3'($urandom);
    qw_addr_i  = AW'($urandom);
    be_ni      = 8'($urandom);
  endtask

  task automatic do_cycle(logic [2:0] t, logic [AW-1:0] a, logic [7:0] ben, int waits);
    @(negedge clk_i);
    addr_strobe_ni = 1'b0; cyc_type_i = t; qw_addr_i = a; be_ni = ben;
    @(negedge clk_i);
    addr_strobe_ni = 1'b1; scramble();
    check_held(t, a, ben, "decode");
    for (int w = 0; w < waits; w++) begin
      @(negedge clk_i); scramble();
      check_held(t, a, ben, "hold R4");
    end
    ready_ni = 1'b0;
    @(negedge clk_i);
    ready_ni = 1'b1;
    chk("R4 release", {kinds(), evt_o, be_err_o, port_sel_o}, 0);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk_i);
    chk("R1 in reset", {kinds(), evt_o, be_err_o, port_sel_o, init_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset", {kinds(), evt_o, be_err_o, port_sel_o, init_o}, 0);

    // directed: every type code
    for (int t = 0; t < 8; t++) do_cycle(3'(t), AW'(100), 8'hF0, t % 3);
    // special events, each lane
    for (int k = 0; k < 8; k++) do_cycle(3'd1, '0, ~(8'h01 << k), 1);
    do_cycle(3'd1, '0, 8'hFF, 0);  // R6 none active
    do_cycle(3'd1, '0, 8'hFC, 0);  // R6 two active
    repeat (20) @(negedge clk_i);

    // R9 port select corners
    do_cycle(3'd3, AW'(8), 8'hF7, 0);
    do_cycle(3'd3, AW'(8), 8'hFB, 0);
    do_cycle(3'd3, AW'(9), 8'hF7, 0);
    do_cycle(3'd2, AW'(8), 8'hF7, 0);

    // R10 ready while idle
    @(negedge clk_i); ready_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    ready_ni = 1'b1;
    chk("R10 idle ready", kinds(), 0);
    // R10 strobe with ready on same edge
    @(negedge clk_i); addr_strobe_ni = 1'b0; cyc_type_i = 3'd6;
    @(negedge clk_i); addr_strobe_ni = 1'b0; ready_ni = 1'b0; cyc_type_i = 3'd3;
    @(negedge clk_i); addr_strobe_ni = 1'b1; ready_ni = 1'b1;
    chk("R10 strobe wins", kinds(), 8'h08);
    ready_ni = 1'b0;
    @(negedge clk_i); ready_ni = 1'b1;

    // R7 pulse start and length
    repeat (20) @(negedge clk_i);
    init_hi = 0;
    @(negedge clk_i); addr_strobe_ni = 1'b0; cyc_type_i = 3'd1; be_ni = 8'hFE;
    @(negedge clk_i); addr_strobe_ni = 1'b1;
    chk("R7 not yet", init_o, 0);
    @(negedge clk_i);
    chk("R7 rise", init_o, 1);
    ready_ni = 1'b0;
    @(negedge clk_i); ready_ni = 1'b1;
    repeat (20) @(negedge clk_i);
    chk("R7 length", init_hi, L);

    // R8 absorb then retrigger
    init_hi = 0;
    do_cycle(3'd1, '0, 8'hFE, 0);
    do_cycle(3'd1, '0, 8'hFE, 0);
    repeat (20) @(negedge clk_i);
    chk("R8 absorbed", init_hi, L);
    init_hi = 0;
    do_cycle(3'd1, '0, 8'hFE, 0);
    repeat (20) @(negedge clk_i);
    chk("R8 retrigger", init_hi, L);

    // random mix
    for (int i = 0; i < 250; i++) begin
      logic [2:0] t = 3'($urandom);
      logic [AW-1:0] a = ($urandom % 4 == 0) ? AW'(8) : AW'($urandom);
      logic [7:0] b = ($urandom % 2 == 0) ? ~(8'h01 << ($urandom % 8)) : 8'($urandom);
      do_cycle(t, a, b, $urandom % 3);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule